// File: doc/BRIEF.md
# Infrared Pulse Train Capture Receiver

This block sits behind a carrier demodulator and timestamps the pulse train that a remote control sends. The system clock is divided down to a sampling tick, 10 MHz in normal use. Every duration is counted in those ticks. For each symbol the receiver records two numbers. The first is the mark length, the time the carrier was present. The second is the whole symbol period, from the start of that mark to the start of the next one. Software can derive the space by subtracting the first number from the second.

Each completed pair is written into a small FIFO, which software drains through a word-addressed register port. When the input stays idle for the programmed maximum symbol period, the open symbol is closed with the period code 0xFFFF. That entry is the last symbol of the train, and the receiver then waits for a fresh inactive-to-active edge.

Four interrupt causes are kept in a status register and gated by an enable register onto one interrupt line: pair received, last symbol, overrun and FIFO full. The register map is: 0x0 control (bit 0 receive enable, bit 1 invert input), 0x1 tick divisor, 0x2 maximum symbol period, 0x3 interrupt enable, 0x4 interrupt status (read only), 0x5 interrupt clear, 0x6 receive status, 0x7 head mark, 0x8 head period. A read of 0x8 pops the head pair.

Top module: `irc_capture_top`

## Requirements
- R1: After reset, control reads 0, the divisor reads its parameter default (25), the maximum period reads 0x5000, receive status and interrupt status read 0, and `irq` is low.
- R2: The sample tick fires once every N clocks, where N is the divisor register (0 acts as 1). Mark and period counts equal the input's durations in ticks.
- R3: Each closed symbol yields a pair. The mark is the number of active ticks. The period counts active plus idle ticks up to the next inactive-to-active edge. Pairs read back in arrival order.
- R4: When control bit 1 is 1, the input is inverted before it is measured, so a low level counts as carrier present.
- R5: When the period would reach the maximum symbol period during idle time, the pair is stored with period 0xFFFF, and interrupt status bit 1 (last symbol) is set.
- R6: While control bit 0 is 0, nothing is captured. After it is set, capture begins only at an inactive-to-active edge, so an input already active at enable is ignored.
- R7: Reading address 0x8 returns the head period and removes the head pair. Receive status bits 15:8 hold the FIFO occupancy, and that field shows the removal one clock after the read.
- R8: The FIFO holds 8 pairs. A pair completed while it is full is dropped and sets interrupt status bit 2 and receive status bit 2. Interrupt status bit 3 is 1 exactly while the occupancy is 8.
- R9: Writing ones to address 0x5 clears the matching sticky status bits 0 to 2. Writing 0x4 clears only the overrun bit.
- R10: `irq` is high exactly when some bit of interrupt status ANDed with interrupt enable is 1. Interrupt status bit 0 is set whenever a pair enters the FIFO.
- R11: The mark and period counters saturate at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Demodulated receiver input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at 0x8) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The input reaches the measurement logic two ticks after it changes. A pair enters the FIFO, and its status bits rise, on the second clock edge after the tick that samples the edge (or the timeout) that closes it. The bench therefore leaves a margin of several clocks after each pulse train before it samples anything. Read data is combinational, so each read is sampled just after the falling edge on which the address is driven. Occupancy is checked at the falling edge that follows the popping rising edge, which is exactly one clock after the read, as R7 states.

// File: rtl/irc_pkg.sv
`timescale 1ns/1ps
package irc_pkg;
    localparam int CNT_W = 16;
    localparam logic [CNT_W-1:0] SYM_TIMEOUT = 16'hFFFF;
    localparam logic [CNT_W-1:0] MAXSYM_RESET = 16'h5000;

    localparam logic [3:0] ADR_CTRL   = 4'h0;
    localparam logic [3:0] ADR_DIV    = 4'h1;
    localparam logic [3:0] ADR_MAXSYM = 4'h2;
    localparam logic [3:0] ADR_IRQEN  = 4'h3;
    localparam logic [3:0] ADR_IRQST  = 4'h4;
    localparam logic [3:0] ADR_IRQCLR = 4'h5;
    localparam logic [3:0] ADR_RXSTAT = 4'h6;
    localparam logic [3:0] ADR_MARK   = 4'h7;
    localparam logic [3:0] ADR_SYM    = 4'h8;

    localparam int IB_RX   = 0;
    localparam int IB_LAST = 1;
    localparam int IB_OVR  = 2;
    localparam int IB_FULL = 3;

    typedef struct packed {
        logic [CNT_W-1:0] mark;
        logic [CNT_W-1:0] sym;
    } pair_t;

    typedef enum logic [1:0] {MS_IDLE, MS_MARK, MS_SPACE} meas_state_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == SYM_TIMEOUT) ? v : v + 16'd1;
    endfunction
endpackage

// File: rtl/irc_tick_gen.sv
`timescale 1ns/1ps
module irc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last_cnt;

    assign last_cnt = (divisor == '0) ? '0 : divisor - 1'b1;
    assign tick     = (cnt >= last_cnt);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R2: with a divisor above one, two ticks never sit back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && divisor > 1) |=> (!tick || divisor <= 1));
endmodule

// File: rtl/irc_measure.sv
`timescale 1ns/1ps
module irc_measure
    import irc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rx_raw,
    input  logic             invert,
    input  logic             enable,
    input  logic [CNT_W-1:0] max_sym,
    output logic             emit_vld,
    output pair_t            emit_pair,
    output logic             emit_last
);
    logic        sync1, sync2, prev;
    logic        rise;
    meas_state_t st;
    logic [CNT_W-1:0] mark_cnt, sym_cnt, sym_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else if (tick) begin
            sync1 <= rx_raw ^ invert;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign rise   = tick && sync2 && !prev;
    assign sym_nx = sat_inc(sym_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= MS_IDLE;
            mark_cnt  <= '0;
            sym_cnt   <= '0;
            emit_vld  <= 1'b0;
            emit_last <= 1'b0;
            emit_pair <= '0;
        end else begin
            emit_vld  <= 1'b0;
            emit_last <= 1'b0;
            if (!enable) begin
                st <= MS_IDLE;
            end else if (tick) begin
                case (st)
                    MS_IDLE: begin
                        if (rise) begin
                            mark_cnt <= 16'd1;
                            sym_cnt  <= 16'd1;
                            st       <= MS_MARK;
                        end
                    end
                    MS_MARK: begin
                        sym_cnt <= sym_nx;
                        if (sync2) mark_cnt <= sat_inc(mark_cnt);
                        else       st <= MS_SPACE;
                    end
                    MS_SPACE: begin
                        if (rise) begin
                            emit_vld       <= 1'b1;
                            emit_pair.mark <= mark_cnt;
                            emit_pair.sym  <= sym_cnt;
                            mark_cnt       <= 16'd1;
                            sym_cnt        <= 16'd1;
                            st             <= MS_MARK;
                        end else if (sym_nx >= max_sym) begin
                            emit_vld       <= 1'b1;
                            emit_last      <= 1'b1;
                            emit_pair.mark <= mark_cnt;
                            emit_pair.sym  <= SYM_TIMEOUT;
                            st             <= MS_IDLE;
                        end else begin
                            sym_cnt <= sym_nx;
                        end
                    end
                    default: st <= MS_IDLE;
                endcase
            end
        end
    end

    // R6: a disabled receiver produces no pair on the next clock
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !emit_vld);
    // R5: a last-symbol entry carries the timeout code
    p_timeout_code_r5: assert property (@(posedge clk) disable iff (rst)
        (emit_vld && emit_last) |-> (emit_pair.sym == SYM_TIMEOUT));
    // R3: a mark never outlasts its own symbol period
    p_mark_in_period_r3: assert property (@(posedge clk) disable iff (rst)
        emit_vld |-> (emit_pair.mark <= emit_pair.sym));
endmodule

// File: rtl/irc_pair_fifo.sv
`timescale 1ns/1ps
module irc_pair_fifo
    import irc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  pair_t                        din,
    input  logic                         pop,
    output pair_t                        head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         accepted,
    output logic                         dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    pair_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_pop;

    assign full     = (count == CW'(DEPTH));
    assign accepted = push && !full;
    assign dropped  = push && full;
    assign do_pop   = pop && (count != '0);
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accepted) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted)
                wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({accepted, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: occupancy never exceeds the depth
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R8: a pair offered to a full FIFO leaves the occupancy untouched
    p_drop_keeps_count_r8: assert property (@(posedge clk) disable iff (rst)
        (dropped && !do_pop) |=> (count == $past(count)));
    // R7: a pop with no push lowers the occupancy by one on the next clock
    p_pop_lowers_r7: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/irc_regs.sv
`timescale 1ns/1ps
module irc_regs
    import irc_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 25,
    parameter int CW        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             irq,
    output logic             rx_enable,
    output logic             rx_invert,
    output logic [DIV_W-1:0] divisor,
    output logic [CNT_W-1:0] max_sym,
    output logic             pop,
    input  pair_t            head,
    input  logic [CW-1:0]    count,
    input  logic             full,
    input  logic             ev_rx,
    input  logic             ev_last,
    input  logic             ev_ovr
);
    logic [3:0] irq_en;
    logic [2:0] sticky;
    logic [3:0] stat_view;
    logic       clr_wr;

    assign clr_wr    = reg_wr && (reg_addr == ADR_IRQCLR);
    assign stat_view = {full, sticky};
    assign irq       = |(stat_view & irq_en);
    assign pop       = reg_rd && (reg_addr == ADR_SYM);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_enable <= 1'b0;
            rx_invert <= 1'b0;
            divisor   <= DIV_W'(DIV_RESET);
            max_sym   <= MAXSYM_RESET;
            irq_en    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL: begin
                    rx_enable <= reg_wdata[0];
                    rx_invert <= reg_wdata[1];
                end
                ADR_DIV:    divisor <= reg_wdata[DIV_W-1:0];
                ADR_MAXSYM: max_sym <= reg_wdata;
                ADR_IRQEN:  irq_en  <= reg_wdata[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= '0;
        end else begin
            for (int b = 0; b < 3; b++) begin
                if (clr_wr && reg_wdata[b]) sticky[b] <= 1'b0;
            end
            if (ev_rx)   sticky[IB_RX]   <= 1'b1;
            if (ev_last) sticky[IB_LAST] <= 1'b1;
            if (ev_ovr)  sticky[IB_OVR]  <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL:   reg_rdata = {14'd0, rx_invert, rx_enable};
            ADR_DIV:    reg_rdata = 16'(divisor);
            ADR_MAXSYM: reg_rdata = max_sym;
            ADR_IRQEN:  reg_rdata = {12'd0, irq_en};
            ADR_IRQST:  reg_rdata = {12'd0, stat_view};
            ADR_RXSTAT: reg_rdata = {8'(count), 5'd0, sticky[IB_OVR], 2'd0};
            ADR_MARK:   reg_rdata = head.mark;
            ADR_SYM:    reg_rdata = head.sym;
            default:    reg_rdata = '0;
        endcase
    end

    // R9: writing 0x4 style clear removes the overrun flag unless a new drop races it
    p_ovr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && reg_wdata[IB_OVR] && !ev_ovr) |=> !sticky[IB_OVR]);
    // R9: a clear that leaves bit 0 at zero keeps a pending receive flag
    p_clear_spares_rx_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !reg_wdata[IB_RX] && sticky[IB_RX]) |=> sticky[IB_RX]);
    // R10: a new pair always raises the receive flag
    p_rx_flag_r10: assert property (@(posedge clk) disable iff (rst)
        ev_rx |=> sticky[IB_RX]);
endmodule

// File: rtl/irc_capture_top.sv
`timescale 1ns/1ps
module irc_capture_top
    import irc_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic             tick, rx_enable, rx_invert, pop;
    logic [DIV_W-1:0] divisor;
    logic [CNT_W-1:0] max_sym;
    logic             emit_vld, emit_last;
    pair_t            emit_pair, head;
    logic [CW-1:0]    count;
    logic             full, accepted, dropped;

    irc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
    );

    irc_measure u_meas (
        .clk(clk), .rst(rst), .tick(tick), .rx_raw(rx_in),
        .invert(rx_invert), .enable(rx_enable), .max_sym(max_sym),
        .emit_vld(emit_vld), .emit_pair(emit_pair), .emit_last(emit_last)
    );

    irc_pair_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(emit_vld), .din(emit_pair), .pop(pop),
        .head(head), .count(count), .full(full),
        .accepted(accepted), .dropped(dropped)
    );

    irc_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .rx_enable(rx_enable), .rx_invert(rx_invert),
        .divisor(divisor), .max_sym(max_sym), .pop(pop),
        .head(head), .count(count), .full(full),
        .ev_rx(accepted), .ev_last(accepted && emit_last), .ev_ovr(dropped)
    );
endmodule

// File: tb/irc_capture_top_test.sv
`timescale 1ns/1ps
module irc_capture_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irc_capture_top uut (
        .clk(clk), .rst(rst), .rx_in(rx_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic level(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_pair(input string req, input logic [15:0] em, input logic [15:0] es);
        logic [15:0] m, s;
        reg_addr = 4'h7;
        #1 m = reg_rdata;
        reg_addr = 4'h8; reg_rd = 1'b1;
        #1 s = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        check({req, " mark"}, m, em);
        check({req, " period"}, s, es);
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [15:0] e);
        logic [15:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    task automatic t_reset;
        expect_reg("R1 ctrl", 4'h0, 16'h0000);
        expect_reg("R1 divisor", 4'h1, 16'd25);
        expect_reg("R1 max period", 4'h2, 16'h5000);
        expect_reg("R1 rx status", 4'h6, 16'h0000);
        expect_reg("R1 irq status", 4'h4, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_basic;
        wr(4'h1, 16'd1);
        wr(4'h2, 16'd40);
        wr(4'h0, 16'h1);
        level(0, 5);
        level(1, 5); level(0, 7);
        level(1, 3); level(0, 4);
        level(1, 2); level(0, 60);
        expect_reg("R7 occupancy 3", 4'h6, 16'h0300);
        expect_reg("R5 last and rx flags", 4'h4, 16'h0003);
        check("R10 irq masked", {15'd0, irq}, 16'h0);
        wr(4'h3, 16'h2);
        check("R10 irq on last", {15'd0, irq}, 16'h1);
        pop_pair("R3 first", 16'd5, 16'd12);
        expect_reg("R7 occupancy after pop", 4'h6, 16'h0200);
        pop_pair("R3 second", 16'd3, 16'd7);
        pop_pair("R5 timeout entry", 16'd2, 16'hFFFF);
        expect_reg("R7 empty", 4'h6, 16'h0000);
        wr(4'h5, 16'h000F);
        expect_reg("R9 all cleared", 4'h4, 16'h0000);
        check("R10 irq low", {15'd0, irq}, 16'h0);
        wr(4'h3, 16'h0);
    endtask

    task automatic t_divider;
        wr(4'h1, 16'd3);
        level(0, 10);
        level(1, 12); level(0, 15);
        level(1, 6); level(0, 150);
        pop_pair("R2 div3 first", 16'd4, 16'd9);
        pop_pair("R2 div3 timeout", 16'd2, 16'hFFFF);
        wr(4'h1, 16'd1);
        wr(4'h5, 16'h000F);
    endtask

    task automatic t_polarity;
        wr(4'h0, 16'h0);
        level(1, 2);
        wr(4'h0, 16'h2);
        level(1, 6);
        wr(4'h0, 16'h3);
        level(1, 4);
        level(0, 6); level(1, 8);
        level(0, 2); level(1, 60);
        pop_pair("R4 inverted first", 16'd6, 16'd14);
        pop_pair("R4 inverted timeout", 16'd2, 16'hFFFF);
        wr(4'h0, 16'h0);
        level(0, 6);
        wr(4'h5, 16'h000F);
    endtask

    task automatic t_enable;
        level(1, 5); level(0, 5); level(1, 5); level(0, 60);
        expect_reg("R6 disabled no capture", 4'h6, 16'h0000);
        level(1, 4);
        wr(4'h0, 16'h1);
        level(1, 10);
        level(0, 10);
        level(1, 4); level(0, 6);
        level(1, 3); level(0, 60);
        expect_reg("R6 two pairs after enable", 4'h6, 16'h0200);
        pop_pair("R6 first after enable", 16'd4, 16'd10);
        pop_pair("R6 timeout after enable", 16'd3, 16'hFFFF);
        wr(4'h5, 16'h000F);
    endtask

    task automatic t_overrun;
        for (int i = 0; i < 10; i++) begin
            level(1, 3); level(0, 3);
        end
        level(0, 60);
        expect_reg("R8 full and overflow", 4'h6, 16'h0804);
        expect_reg("R8 status rx ovr full", 4'h4, 16'h000D);
        wr(4'h5, 16'h0004);
        expect_reg("R9 only overrun cleared", 4'h4, 16'h0009);
        expect_reg("R9 overflow bit gone", 4'h6, 16'h0800);
        for (int i = 0; i < 8; i++) pop_pair("R8 kept pair", 16'd3, 16'd6);
        expect_reg("R8 full bit drops", 4'h4, 16'h0001);
        wr(4'h5, 16'h000F);
    endtask

    task automatic t_saturate;
        wr(4'h2, 16'h5000);
        level(1, 70000);
        level(0, 20);
        expect_reg("R11 one entry", 4'h6, 16'h0100);
        pop_pair("R11 saturated", 16'hFFFF, 16'hFFFF);
        wr(4'h5, 16'h000F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_divider();
        t_polarity();
        t_enable();
        t_overrun();
        t_saturate();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule